// File: doc/BRIEF.md
# Credited Transaction Originator Port

This block is the requesting end of a split-transaction link between accelerators. A local client hands it read, write, atomic and write-message commands. The port gives each command a transaction tag and drives it onto an outbound request channel. For commands that carry data, the port drives the write payload onto an outbound originator-data channel, and the first beat goes out in the same cycle as the request. The port sends only while it holds credits that the far end has returned. Request and data credits are counted separately.

Completions arrive on two inbound channels. The read-response channel carries completions for reads and value-returning atomics, and it can carry several data beats. The write-response channel carries completions for writes, non-returning atomics and write messages. The port checks each response against its table of outstanding tags and forwards it to the client. A tag returns to the pool once its transaction is complete. A response that breaks the rules is dropped and latches an error flag. After reset the port raises a clock request and issues nothing until the far end acknowledges it.

Top module: `txn_orig_port`

## Requirements
- R1: `clk_req_o` is 0 during reset and 1 from the first clock edge after reset is released. `cmd_ready_o` stays 0, and no request or data beat is sent, until a clock edge samples `clk_ack_i` high while `clk_req_o` is high. From then on the link stays up until reset.
- R2: Operation codes are 0 read, 1 write, 2 value-returning atomic, 3 non-returning atomic and 4 write message. Codes 5 to 7 behave like a write message. A command is accepted in the cycle where `cmd_valid_i` and `cmd_ready_o` are both high. In that cycle `req_valid_o` is 1 and op, destination, address and length are copied combinationally from the command.
- R3: For every code except 0, acceptance needs `wdat_valid_i`. The first beat appears on `odat_*` in the same cycle as the request, with `odat_tag_o` equal to `req_tag_o`. The following `cmd_len_i` cycles each carry one more beat when data is valid and credited. `odat_last_o` marks the final beat, and no new command is accepted while a burst is open.
- R4: The request credit count starts at REQ_CRED_MAX. Each request takes one credit and each `req_cred_rtn_i` pulse gives one back. `cmd_ready_o` is 0 while the count is 0.
- R5: The data credit count starts at DAT_CRED_MAX, and every data beat, including the first, takes one credit. A data command needs a request credit and a data credit together. A burst pauses (`wdat_ready_o` and `odat_valid_o` low) while the data credit count is 0.
- R6: Each request gets the lowest-numbered free tag out of NUM_TAGS. `cmd_ready_o` is 0 while all tags are outstanding.
- R7: Read and value-returning atomic tags complete on the read channel. Each legal beat is forwarded on `rd_data_*`. The tag is freed on the beat that brings the count of received beats up to `rd_rsp_beats_i`, and that beat shows `rd_last_o` = 1.
- R8: Write, non-returning atomic and write-message tags complete with one legal write response. That response is forwarded on `wr_done_*` and frees the tag.
- R9: A response is dropped (no client valid, tag state unchanged) and `prot_err_o` is set on the next edge in three cases: its tag is not outstanding, it arrives on the wrong channel for the tag's operation, or it is a read beat with a beat count of 0.
- R10: A credit return that arrives while its counter is at the maximum and no credit is being used leaves the counter at the maximum and sets `prot_err_o`.
- R11: `prot_err_o` is 0 after reset and, once set, stays set until reset.
- R12: In a single cycle a final read beat, a write response and a new request can all happen. Both tags are freed, and the new request gets a tag that was already free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clk_req_o | output | 1 | Clock request toward the far end |
| clk_ack_i | input | 1 | Clock acknowledge from the far end |
| cmd_valid_i | input | 1 | Client command valid |
| cmd_ready_o | output | 1 | Command accepted this cycle when valid |
| cmd_op_i | input | 3 | Operation code |
| cmd_dst_i | input | DST_W | Destination identifier |
| cmd_addr_i | input | ADDR_W | Target address |
| cmd_len_i | input | LEN_W | Data beats after the first |
| wdat_valid_i | input | 1 | Client write data valid |
| wdat_ready_o | output | 1 | Write beat taken this cycle |
| wdat_i | input | DATA_W | Client write data |
| req_valid_o | output | 1 | Request channel valid |
| req_op_o | output | 3 | Request operation |
| req_dst_o | output | DST_W | Request destination |
| req_addr_o | output | ADDR_W | Request address |
| req_len_o | output | LEN_W | Request extra beat count |
| req_tag_o | output | TAG_W | Request tag |
| odat_valid_o | output | 1 | Originator data beat valid |
| odat_data_o | output | DATA_W | Originator data beat |
| odat_tag_o | output | TAG_W | Tag of the data beat |
| odat_last_o | output | 1 | Final beat of the burst |
| req_cred_rtn_i | input | 1 | One request credit returned |
| dat_cred_rtn_i | input | 1 | One data credit returned |
| rd_rsp_valid_i | input | 1 | Read response beat valid |
| rd_rsp_tag_i | input | TAG_W | Read response tag |
| rd_rsp_beats_i | input | BEAT_W | Total beats of this read response |
| rd_rsp_data_i | input | DATA_W | Read response data |
| rd_data_valid_o | output | 1 | Legal read beat to client |
| rd_data_o | output | DATA_W | Read data to client |
| rd_tag_o | output | TAG_W | Tag of read beat |
| rd_last_o | output | 1 | Final beat, tag freed |
| wr_rsp_valid_i | input | 1 | Write response valid |
| wr_rsp_tag_i | input | TAG_W | Write response tag |
| wr_done_valid_o | output | 1 | Legal write completion to client |
| wr_done_tag_o | output | TAG_W | Completed write tag |
| prot_err_o | output | 1 | Sticky protocol error |

## Verification
Tag release and tag allocation share one pool, and up to three pool events can fall in a single cycle: a final read beat, a write response and a new request. The bench first fills all sixteen tags with fifteen reads and one write, then frees one read tag so that exactly one free tag exists. In the following cycle it drives a command, the last beat of a second read and the write's response together. It checks that the new request takes the one tag that was free, that both completions reach the client, and that the next two requests take the two tags freed in that cycle, lowest first, with no error raised.

// File: rtl/txn_pkg.sv
package txn_pkg;
  typedef enum logic [2:0] {
    OP_READ      = 3'd0,
    OP_WRITE     = 3'd1,
    OP_ATOM_RET  = 3'd2,
    OP_ATOM_NRET = 3'd3,
    OP_WMSG      = 3'd4
  } op_e;

  function automatic logic op_has_data(logic [2:0] op);
    return op != OP_READ;
  endfunction

  function automatic logic op_rd_class(logic [2:0] op);
    return (op == OP_READ) || (op == OP_ATOM_RET);
  endfunction
endpackage

// File: rtl/txn_credit_ctr.sv
module txn_credit_ctr #(
  parameter int MAX = 4,
  parameter int W   = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         use_i,
  input  logic         rtn_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q;
  logic         at_max;

  assign at_max = (cnt_q == W'(MAX));
  assign ovf_o  = rtn_i & ~use_i & at_max;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= W'(MAX);
    else begin
      case ({use_i, rtn_i})
        2'b10:   cnt_q <= cnt_q - W'(1);
        2'b01:   if (!at_max) cnt_q <= cnt_q + W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/txn_tag_pool.sv
module txn_tag_pool #(
  parameter int N  = 16,
  parameter int BW = 4,
  localparam int TW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          alloc_i,
  input  logic          alloc_rd_i,
  output logic [TW-1:0] alloc_tag_o,
  input  logic          rd_vld_i,
  input  logic [TW-1:0] rd_tag_i,
  input  logic [BW-1:0] rd_beats_i,
  output logic          rd_ok_o,
  output logic          rd_final_o,
  input  logic          wr_vld_i,
  input  logic [TW-1:0] wr_tag_i,
  output logic          wr_ok_o,
  output logic [N-1:0]  busy_o
);
  logic [N-1:0]  busy_q, isrd_q;
  logic [BW-1:0] cnt_q [N];

  always_comb begin
    alloc_tag_o = '0;
    for (int i = N - 1; i >= 0; i--)
      if (!busy_q[i]) alloc_tag_o = TW'(i);
  end

  assign rd_ok_o    = rd_vld_i & busy_q[rd_tag_i] & isrd_q[rd_tag_i] & (rd_beats_i != '0);
  assign rd_final_o = rd_ok_o & (({1'b0, cnt_q[rd_tag_i]} + (BW+1)'(1)) == {1'b0, rd_beats_i});
  assign wr_ok_o    = wr_vld_i & busy_q[wr_tag_i] & ~isrd_q[wr_tag_i];
  assign busy_o     = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= '0;
      isrd_q <= '0;
      for (int i = 0; i < N; i++) cnt_q[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (alloc_i && alloc_tag_o == TW'(i)) begin
          busy_q[i] <= 1'b1;
          isrd_q[i] <= alloc_rd_i;
          cnt_q[i]  <= '0;
        end else if (rd_final_o && rd_tag_i == TW'(i)) begin
          busy_q[i] <= 1'b0;
          cnt_q[i]  <= '0;
        end else if (rd_ok_o && rd_tag_i == TW'(i)) begin
          cnt_q[i]  <= cnt_q[i] + BW'(1);
        end else if (wr_ok_o && wr_tag_i == TW'(i)) begin
          busy_q[i] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/txn_orig_port.sv
module txn_orig_port
  import txn_pkg::*;
#(
  parameter int NUM_TAGS     = 16,
  parameter int ADDR_W       = 32,
  parameter int DATA_W       = 32,
  parameter int DST_W        = 4,
  parameter int LEN_W        = 4,
  parameter int BEAT_W       = 4,
  parameter int REQ_CRED_MAX = 4,
  parameter int DAT_CRED_MAX = 6,
  localparam int TAG_W       = $clog2(NUM_TAGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              clk_req_o,
  input  logic              clk_ack_i,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [2:0]        cmd_op_i,
  input  logic [DST_W-1:0]  cmd_dst_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [LEN_W-1:0]  cmd_len_i,
  input  logic              wdat_valid_i,
  output logic              wdat_ready_o,
  input  logic [DATA_W-1:0] wdat_i,
  output logic              req_valid_o,
  output logic [2:0]        req_op_o,
  output logic [DST_W-1:0]  req_dst_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [LEN_W-1:0]  req_len_o,
  output logic [TAG_W-1:0]  req_tag_o,
  output logic              odat_valid_o,
  output logic [DATA_W-1:0] odat_data_o,
  output logic [TAG_W-1:0]  odat_tag_o,
  output logic              odat_last_o,
  input  logic              req_cred_rtn_i,
  input  logic              dat_cred_rtn_i,
  input  logic              rd_rsp_valid_i,
  input  logic [TAG_W-1:0]  rd_rsp_tag_i,
  input  logic [BEAT_W-1:0] rd_rsp_beats_i,
  input  logic [DATA_W-1:0] rd_rsp_data_i,
  output logic              rd_data_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic              rd_last_o,
  input  logic              wr_rsp_valid_i,
  input  logic [TAG_W-1:0]  wr_rsp_tag_i,
  output logic              wr_done_valid_o,
  output logic [TAG_W-1:0]  wr_done_tag_o,
  output logic              prot_err_o
);
  localparam int CMAX = (REQ_CRED_MAX > DAT_CRED_MAX) ? REQ_CRED_MAX : DAT_CRED_MAX;
  localparam int CW   = $clog2(CMAX + 1);

  // link bring-up
  logic clk_req_q, link_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_req_q <= 1'b0;
      link_q    <= 1'b0;
    end else begin
      clk_req_q <= 1'b1;
      link_q    <= link_q | (clk_req_q & clk_ack_i);
    end
  end
  assign clk_req_o = clk_req_q;

  // credits: index 0 request, 1 data
  logic [1:0]    cred_use, cred_rtn, cred_ovf, cred_avail;
  logic [CW-1:0] cred_cnt [2];
  assign cred_rtn = {dat_cred_rtn_i, req_cred_rtn_i};

  for (genvar c = 0; c < 2; c++) begin : g_cred
    localparam int LIM = (c == 0) ? REQ_CRED_MAX : DAT_CRED_MAX;
    txn_credit_ctr #(.MAX(LIM), .W(CW)) u_ctr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .use_i (cred_use[c]),
      .rtn_i (cred_rtn[c]),
      .cnt_o (cred_cnt[c]),
      .ovf_o (cred_ovf[c])
    );
    assign cred_avail[c] = (cred_cnt[c] != '0);
  end

  logic [CW-1:0] req_cnt, dat_cnt;
  assign req_cnt = cred_cnt[0];
  assign dat_cnt = cred_cnt[1];

  // tag pool
  logic [NUM_TAGS-1:0] tag_busy;
  logic [TAG_W-1:0]    alloc_tag;
  logic                tag_avail, rd_ok, rd_final, wr_ok;
  logic                cmd_data, cmd_fire, first_beat, burst_beat;
  assign tag_avail = ~&tag_busy;

  txn_tag_pool #(.N(NUM_TAGS), .BW(BEAT_W)) u_pool (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .alloc_i    (cmd_fire),
    .alloc_rd_i (op_rd_class(cmd_op_i)),
    .alloc_tag_o(alloc_tag),
    .rd_vld_i   (rd_rsp_valid_i),
    .rd_tag_i   (rd_rsp_tag_i),
    .rd_beats_i (rd_rsp_beats_i),
    .rd_ok_o    (rd_ok),
    .rd_final_o (rd_final),
    .wr_vld_i   (wr_rsp_valid_i),
    .wr_tag_i   (wr_rsp_tag_i),
    .wr_ok_o    (wr_ok),
    .busy_o     (tag_busy)
  );

  // issue and data burst
  logic             burst_q;
  logic [LEN_W-1:0] rem_q;
  logic [TAG_W-1:0] btag_q;

  assign cmd_data    = op_has_data(cmd_op_i);
  assign cmd_ready_o = link_q & ~burst_q & tag_avail & cred_avail[0]
                     & (~cmd_data | (cred_avail[1] & wdat_valid_i));
  assign cmd_fire    = cmd_valid_i & cmd_ready_o;
  assign first_beat  = cmd_fire & cmd_data;
  assign burst_beat  = burst_q & wdat_valid_i & cred_avail[1];
  assign cred_use    = {first_beat | burst_beat, cmd_fire};

  assign req_valid_o  = cmd_fire;
  assign req_op_o     = cmd_op_i;
  assign req_dst_o    = cmd_dst_i;
  assign req_addr_o   = cmd_addr_i;
  assign req_len_o    = cmd_len_i;
  assign req_tag_o    = alloc_tag;
  assign wdat_ready_o = burst_q ? cred_avail[1] : first_beat;
  assign odat_valid_o = first_beat | burst_beat;
  assign odat_data_o  = wdat_i;
  assign odat_tag_o   = burst_q ? btag_q : alloc_tag;
  assign odat_last_o  = burst_q ? (rem_q == LEN_W'(1)) : (cmd_len_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      burst_q <= 1'b0;
      rem_q   <= '0;
      btag_q  <= '0;
    end else if (first_beat && cmd_len_i != '0) begin
      burst_q <= 1'b1;
      rem_q   <= cmd_len_i;
      btag_q  <= alloc_tag;
    end else if (burst_beat) begin
      rem_q <= rem_q - LEN_W'(1);
      if (rem_q == LEN_W'(1)) burst_q <= 1'b0;
    end
  end

  // completions
  assign rd_data_valid_o = rd_ok;
  assign rd_data_o       = rd_rsp_data_i;
  assign rd_tag_o        = rd_rsp_tag_i;
  assign rd_last_o       = rd_final;
  assign wr_done_valid_o = wr_ok;
  assign wr_done_tag_o   = wr_rsp_tag_i;

  logic err_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else err_q <= err_q | (rd_rsp_valid_i & ~rd_ok) | (wr_rsp_valid_i & ~wr_ok) | (|cred_ovf);
  end
  assign prot_err_o = err_q;
endmodule

// File: rtl/txn_orig_port_chk.sv
module txn_orig_port_chk
  import txn_pkg::*;
#(
  parameter int NT   = 16,
  parameter int TW   = 4,
  parameter int CW   = 3,
  parameter int RMAX = 4,
  parameter int DMAX = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          link_q,
  input logic          clk_ack_i,
  input logic          req_valid_o,
  input logic [2:0]    req_op_o,
  input logic [TW-1:0] req_tag_o,
  input logic          odat_valid_o,
  input logic [TW-1:0] odat_tag_o,
  input logic          prot_err_o,
  input logic [CW-1:0] req_cnt,
  input logic [CW-1:0] dat_cnt,
  input logic [NT-1:0] tag_busy
);
  a_r1_quiet_until_link: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_q |-> (!req_valid_o && !odat_valid_o));
  a_r1_link_needs_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_q) |-> $past(clk_ack_i));
  a_r3_first_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && op_has_data(req_op_o)) |-> (odat_valid_o && odat_tag_o == req_tag_o));
  a_r4_req_credit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_cnt != '0));
  a_r5_dat_credit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    odat_valid_o |-> (dat_cnt != '0));
  a_r6_fresh_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> !tag_busy[req_tag_o]);
  a_r6_tag_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |=> tag_busy[$past(req_tag_o)]);
  a_r10_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_cnt <= CW'(RMAX)) && (dat_cnt <= CW'(DMAX)));
  a_r11_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_err_o |=> prot_err_o);
endmodule

bind txn_orig_port txn_orig_port_chk #(
  .NT(NUM_TAGS), .TW(TAG_W), .CW(CW), .RMAX(REQ_CRED_MAX), .DMAX(DAT_CRED_MAX)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .link_q      (link_q),
  .clk_ack_i   (clk_ack_i),
  .req_valid_o (req_valid_o),
  .req_op_o    (req_op_o),
  .req_tag_o   (req_tag_o),
  .odat_valid_o(odat_valid_o),
  .odat_tag_o  (odat_tag_o),
  .prot_err_o  (prot_err_o),
  .req_cnt     (req_cnt),
  .dat_cnt     (dat_cnt),
  .tag_busy    (tag_busy)
);

// File: tb/sim_txn_orig_port.sv
module sim_txn_orig_port;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        clk_req_o, clk_ack_i;
  logic        cmd_valid_i, cmd_ready_o;
  logic [2:0]  cmd_op_i;
  logic [3:0]  cmd_dst_i;
  logic [31:0] cmd_addr_i;
  logic [3:0]  cmd_len_i;
  logic        wdat_valid_i, wdat_ready_o;
  logic [31:0] wdat_i;
  logic        req_valid_o;
  logic [2:0]  req_op_o;
  logic [3:0]  req_dst_o;
  logic [31:0] req_addr_o;
  logic [3:0]  req_len_o, req_tag_o;
  logic        odat_valid_o, odat_last_o;
  logic [31:0] odat_data_o;
  logic [3:0]  odat_tag_o;
  logic        req_cred_rtn_i, dat_cred_rtn_i;
  logic        rd_rsp_valid_i;
  logic [3:0]  rd_rsp_tag_i, rd_rsp_beats_i;
  logic [31:0] rd_rsp_data_i;
  logic        rd_data_valid_o, rd_last_o;
  logic [31:0] rd_data_o;
  logic [3:0]  rd_tag_o;
  logic        wr_rsp_valid_i;
  logic [3:0]  wr_rsp_tag_i;
  logic        wr_done_valid_o;
  logic [3:0]  wr_done_tag_o;
  logic        prot_err_o;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  txn_orig_port u0 (.*);

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", rq, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk_i);
  endtask

  task automatic idle_inputs();
    cmd_valid_i = 0; cmd_op_i = 0; cmd_dst_i = 0; cmd_addr_i = 0; cmd_len_i = 0;
    wdat_valid_i = 0; wdat_i = 0; req_cred_rtn_i = 0; dat_cred_rtn_i = 0;
    rd_rsp_valid_i = 0; rd_rsp_tag_i = 0; rd_rsp_beats_i = 0; rd_rsp_data_i = 0;
    wr_rsp_valid_i = 0; wr_rsp_tag_i = 0;
  endtask

  // reset and link bring-up, checks R1 and R11 reset values
  task automatic do_reset();
    rst_ni = 0; clk_ack_i = 0; idle_inputs();
    repeat (3) cyc();
    #1;
    chk("R1 clk_req in reset", clk_req_o, 0);
    chk("R11 err in reset", prot_err_o, 0);
    rst_ni = 1;
    cyc();
    cmd_valid_i = 1; cmd_op_i = 3'd0;
    #1;
    chk("R1 clk_req after reset", clk_req_o, 1);
    chk("R1 no ready before ack", cmd_ready_o, 0);
    cyc(); #1;
    chk("R1 still no ready", cmd_ready_o, 0);
    clk_ack_i = 1; #1;
    chk("R1 ready waits for edge", cmd_ready_o, 0);
    cyc(); #1;
    chk("R1 ready after ack", cmd_ready_o, 1);
    cmd_valid_i = 0;
  endtask

  // issue one command; data beats follow; rtn returns credits as used
  task automatic issue(input logic [2:0] op, input int len, input int exp_tag,
                       input bit rtn, input string rq);
    cmd_valid_i = 1; cmd_op_i = op; cmd_len_i = len[3:0];
    cmd_dst_i = 4'(exp_tag) ^ 4'hA; cmd_addr_i = 32'h1000 + 32'(exp_tag * 16);
    wdat_valid_i = (op != 0); wdat_i = 32'hD000_0000 + 32'(exp_tag);
    req_cred_rtn_i = rtn; dat_cred_rtn_i = rtn & (op != 0);
    #1;
    chk({rq, " req_valid"}, req_valid_o, 1);
    chk({rq, " R6 tag"}, req_tag_o, exp_tag);
    chk({rq, " R2 op"}, req_op_o, op);
    chk({rq, " R2 dst"}, req_dst_o, 4'(exp_tag) ^ 4'hA);
    chk({rq, " R2 addr"}, req_addr_o, 32'h1000 + 32'(exp_tag * 16));
    chk({rq, " R3 first beat"}, odat_valid_o, op != 0);
    if (op != 0) begin
      chk({rq, " R3 beat tag"}, odat_tag_o, exp_tag);
      chk({rq, " R3 first last"}, odat_last_o, len == 0);
    end
    cyc();
    cmd_valid_i = 0; req_cred_rtn_i = 0;
    for (int k = 1; k <= len; k++) begin
      wdat_i = 32'hB000_0000 + 32'(k);
      #1;
      chk({rq, " R3 burst beat"}, odat_valid_o, 1);
      chk({rq, " R3 burst tag"}, odat_tag_o, exp_tag);
      chk({rq, " R3 burst last"}, odat_last_o, k == len);
      chk({rq, " R3 burst data"}, odat_data_o, 32'hB000_0000 + 32'(k));
      cyc();
    end
    wdat_valid_i = 0; dat_cred_rtn_i = 0;
  endtask

  task automatic rd_beat(input int tag, input int beats, input bit ev, input bit el,
                         input string rq);
    rd_rsp_valid_i = 1; rd_rsp_tag_i = 4'(tag); rd_rsp_beats_i = 4'(beats);
    rd_rsp_data_i = 32'hCAFE_0000 + 32'(tag);
    #1;
    chk({rq, " rd valid"}, rd_data_valid_o, ev);
    if (ev) begin
      chk({rq, " rd last"}, rd_last_o, el);
      chk({rq, " rd data"}, rd_data_o, 32'hCAFE_0000 + 32'(tag));
      chk({rq, " rd tag"}, rd_tag_o, tag);
    end
    cyc();
    rd_rsp_valid_i = 0;
  endtask

  task automatic wr_rsp(input int tag, input bit ev, input string rq);
    wr_rsp_valid_i = 1; wr_rsp_tag_i = 4'(tag);
    #1;
    chk({rq, " wr valid"}, wr_done_valid_o, ev);
    if (ev) chk({rq, " wr tag"}, wr_done_tag_o, tag);
    cyc();
    wr_rsp_valid_i = 0;
  endtask

  task automatic t_read_path();
    issue(3'd0, 0, 0, 1, "R2 read");
    rd_beat(0, 2, 1, 0, "R7 beat1");
    rd_beat(0, 2, 1, 1, "R7 beat2");
    issue(3'd0, 0, 0, 1, "R7 tag reused");
    rd_beat(0, 1, 1, 1, "R7 single");
    #1 chk("R9 no err read path", prot_err_o, 0);
  endtask

  task automatic t_write_path();
    issue(3'd1, 2, 0, 1, "R3 write burst");
    issue(3'd3, 0, 1, 1, "R3 atomic noret");
    issue(3'd2, 0, 2, 1, "R3 atomic ret");
    wr_rsp(0, 1, "R8 write done");
    rd_beat(2, 1, 1, 1, "R7 atomic ret done");
    wr_rsp(1, 1, "R8 atomic done");
    issue(3'd0, 0, 0, 1, "R6 lowest free");
    rd_beat(0, 1, 1, 1, "R7 cleanup");
    #1 chk("R8 no err write path", prot_err_o, 0);
  endtask

  task automatic t_credits();
    for (int i = 0; i < 4; i++) issue(3'd0, 0, i, 0, "R4 drain");
    cmd_valid_i = 1; cmd_op_i = 0; #1;
    chk("R4 stall at zero", cmd_ready_o, 0);
    cmd_valid_i = 0; req_cred_rtn_i = 1;
    cyc(); req_cred_rtn_i = 0;
    issue(3'd0, 0, 4, 0, "R4 after return");
    for (int i = 0; i < 4; i++) begin req_cred_rtn_i = 1; cyc(); end
    req_cred_rtn_i = 0;
    for (int i = 0; i < 5; i++) rd_beat(i, 1, 1, 1, "R4 release");
    // data credits: 8 beats against 6 credits
    cmd_valid_i = 1; cmd_op_i = 3'd1; cmd_len_i = 4'd7; wdat_valid_i = 1; #1;
    chk("R5 write accepted", req_valid_o, 1);
    cyc(); cmd_valid_i = 0;
    for (int k = 1; k <= 5; k++) begin #1 chk("R5 credited beat", odat_valid_o, 1); cyc(); end
    #1;
    chk("R5 stall ready", wdat_ready_o, 0);
    chk("R5 stall valid", odat_valid_o, 0);
    dat_cred_rtn_i = 1; cyc(); dat_cred_rtn_i = 0; #1;
    chk("R5 resume beat7", odat_valid_o, 1);
    chk("R5 beat7 not last", odat_last_o, 0);
    cyc(); #1;
    chk("R5 stall again", odat_valid_o, 0);
    dat_cred_rtn_i = 1; cyc(); dat_cred_rtn_i = 0; #1;
    chk("R5 beat8", odat_valid_o, 1);
    chk("R3 beat8 last", odat_last_o, 1);
    cyc(); wdat_valid_i = 0;
    cmd_valid_i = 1; cmd_op_i = 3'd1; cmd_len_i = 0; wdat_valid_i = 1; #1;
    chk("R5 data cmd blocked", cmd_ready_o, 0);
    cmd_op_i = 3'd0; wdat_valid_i = 0; #1;
    chk("R5 read cmd allowed", cmd_ready_o, 1);
    cmd_valid_i = 0;
    for (int i = 0; i < 6; i++) begin dat_cred_rtn_i = 1; req_cred_rtn_i = (i == 0); cyc(); end
    dat_cred_rtn_i = 0; req_cred_rtn_i = 0;
    wr_rsp(0, 1, "R8 long write done");
    #1 chk("R10 no err on exact refill", prot_err_o, 0);
  endtask

  task automatic t_tags();
    for (int i = 0; i < 15; i++) issue(3'd0, 0, i, 1, "R6 fill");
    issue(3'd1, 0, 15, 1, "R6 fill write");
    cmd_valid_i = 1; cmd_op_i = 0; #1;
    chk("R6 pool empty stall", cmd_ready_o, 0);
    cmd_valid_i = 0;
    rd_beat(9, 1, 1, 1, "R7 free 9");
    // R12: allocation plus two releases in one cycle
    cmd_valid_i = 1; cmd_op_i = 0; cmd_dst_i = 0; cmd_addr_i = 0; req_cred_rtn_i = 1;
    rd_rsp_valid_i = 1; rd_rsp_tag_i = 4'd3; rd_rsp_beats_i = 4'd1;
    wr_rsp_valid_i = 1; wr_rsp_tag_i = 4'd15;
    #1;
    chk("R12 new tag", req_tag_o, 9);
    chk("R12 req valid", req_valid_o, 1);
    chk("R12 rd last", rd_last_o, 1);
    chk("R12 wr done", wr_done_valid_o, 1);
    cyc();
    cmd_valid_i = 0; req_cred_rtn_i = 0; rd_rsp_valid_i = 0; wr_rsp_valid_i = 0;
    issue(3'd0, 0, 3, 1, "R12 reuse 3");
    issue(3'd0, 0, 15, 1, "R12 reuse 15");
    cmd_valid_i = 1; #1;
    chk("R6 full again", cmd_ready_o, 0);
    chk("R12 no err", prot_err_o, 0);
    cmd_valid_i = 0;
    for (int i = 0; i < 16; i++) rd_beat(i, 1, 1, 1, "R7 drain");
  endtask

  task automatic t_errors();
    rd_beat(5, 1, 0, 0, "R9 unknown tag");
    #1 chk("R9 err set", prot_err_o, 1);
    repeat (3) cyc();
    #1 chk("R11 sticky", prot_err_o, 1);
    do_reset();
    issue(3'd1, 0, 0, 1, "R9 write for channel test");
    rd_beat(0, 1, 0, 0, "R9 wrong channel");
    #1 chk("R9 err wrong channel", prot_err_o, 1);
    wr_rsp(0, 1, "R9 tag kept after drop");
    do_reset();
    issue(3'd0, 0, 0, 1, "R9 read for zero count");
    rd_beat(0, 0, 0, 0, "R9 zero beats");
    #1 chk("R9 err zero beats", prot_err_o, 1);
    rd_beat(0, 1, 1, 1, "R9 tag kept");
    do_reset();
    req_cred_rtn_i = 1; cyc(); req_cred_rtn_i = 0; #1;
    chk("R10 overflow err", prot_err_o, 1);
    for (int i = 0; i < 4; i++) issue(3'd0, 0, i, 0, "R10 count held");
    cmd_valid_i = 1; #1;
    chk("R10 stays at max", cmd_ready_o, 0);
    cmd_valid_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle_inputs(); clk_ack_i = 0;
    do_reset();
    t_read_path();
    t_write_path();
    t_credits();
    t_tags();
    t_errors();
    repeat (2) cyc();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule